// File: doc/BRIEF.md
# Multiplexed Bus Master Cycle and Arbitration Controller

This block is the bus master side of a shared 16-bit bus that carries address and data on the same wires at different times. The core hands it one transfer at a time: address, write data, direction, memory or I/O space, data or instruction fetch, and whether the bus should stay locked afterwards. The controller asks an external arbiter for the bus. It starts the cycle once it holds a grant and the shared busy and lock lines show the bus is free and unlocked. It then runs an address phase and a data phase, each stretched by its own ready input. For reads, it returns the captured data with a single-cycle done pulse.

The state machine has seven states. IDLE waits for a request. ARB requests the bus. ADR is the first address clock, with the address strobe high. AWAIT is the second address clock and any address wait states. DAT is the first data clock, with the data strobe low. DEND is the last data clock and any data wait states. HOLD keeps ownership between locked cycles.

The transitions are as follows:
- accept (IDLE to ARB)
- won (ARB to ADR, when grant is low and the busy and lock inputs are high)
- strobe_off (ADR to AWAIT)
- addr_ready (AWAIT to DAT when address-ready is high)
- data_go (DAT to DEND)
- finish_free (DEND to IDLE when data-ready is high on an unlocked transfer)
- finish_locked (DEND to HOLD when data-ready is high on a locked transfer)
- chain (HOLD to ADR on a new request, without arbitration)

The pins that would float are modelled as value outputs plus two drive-enable outputs.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `bus_req_n` is 1, `ctl_oe`, `ib_oe` and `done` are 0.
- R2: From the clock after a request is accepted out of IDLE, `bus_req_n` is 0 until the address phase starts, then returns to 1.
- R3: The cycle begins only on a clock edge where `bus_gnt_n` is 0, `lock_in_n` is 1 and `busy_in_n` is 1; any blocker keeps the controller requesting.
- R4: While `bus_gnt_n` is 1 or the bus is not owned, `ctl_oe` and `ib_oe` are 0.
- R5: The address strobe `strba` is 1 for exactly the first address clock and 0 afterwards. The address is on `ib_out` with `ib_oe` 1 throughout the address phase. Each clock with `rdya` 0 in the second address clock adds one clock.
- R6: `strbd_n` is 0 for the whole data phase, and each clock with `rdyd` 0 at its last clock adds one clock. A write drives the write data with `ib_oe` 1; a read sets `ib_oe` to 0. `rdyd` has no effect during the address phase.
- R7: With both ready inputs high a cycle takes 4 clocks from the first address clock to the clock showing `done`, and 4 plus the wait states in general.
- R8: The status encodings are: `rd_wr` is 1 for a read and 0 for a write; `mem_io` is 1 for memory and 0 for I/O; `dat_ins` is 1 for data and 0 for instruction.
- R9: `busy_out_n` is 0 during every bus cycle, and `lock_out_n` equals it during unlocked operation.
- R10: After a cycle requested with `req_lock` 1, the bus stays owned with `lock_out_n` 0 between cycles. The next request starts its address phase on the following clock with no new bus request, and the lock is released after the first cycle requested with `req_lock` 0.
- R11: Read data on `ib_in` is captured at the edge that ends the data phase and shown on `rd_data` together with `done`, which is 1 for exactly one clock.
- R12: `req_ready` is 0 from acceptance until the cycle ends, so requests are ignored meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_data | input | 1 | 1 = data, 0 = instruction |
| req_lock | input | 1 | Keep bus locked after this cycle |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-clock completion pulse |
| bus_req_n | output | 1 | Bus request to arbiter, active low |
| bus_gnt_n | input | 1 | Grant from arbiter, active low |
| busy_in_n | input | 1 | Sensed shared busy line |
| lock_in_n | input | 1 | Sensed shared lock line |
| busy_out_n | output | 1 | Busy value driven when owned |
| lock_out_n | output | 1 | Lock value driven when owned |
| rdya | input | 1 | Address-phase ready |
| rdyd | input | 1 | Data-phase ready |
| ib_in | input | 16 | Sensed bus value |
| ib_out | output | 16 | Bus value to drive |
| ib_oe | output | 1 | Bus drive enable |
| ctl_oe | output | 1 | Enable for strobes, status, busy and lock |
| strba | output | 1 | Address strobe, active high |
| strbd_n | output | 1 | Data strobe, active low |
| rd_wr | output | 1 | Direction status |
| mem_io | output | 1 | Space status |
| dat_ins | output | 1 | Data/instruction status |

## Verification
The hardest situation to reach from the ports is a locked chain that sits in HOLD. There, the grant is withdrawn and the enables must drop. The next request must then start without any bus request, while the lock line stays low with busy high. The stimulus builds this with a directed sequence of two locked transfers and one closing unlocked transfer, and pulls the grant between them. Around it, random transfers mix wait-state counts on both ready inputs with random arbitration blockers: grant held off, lock sensed low, or busy sensed low. Each transfer's strobe and phase timing is compared with bench-computed cycle counts.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    parameter int BUS_W = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_ARB, S_ADR, S_AWAIT, S_DAT, S_DEND, S_HOLD
    } bus_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
        logic             write;
        logic             mem;
        logic             dat;
        logic             lock;
    } xact_t;
endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       cur_lock,
    input  logic       gnt_n,
    input  logic       lock_in_n,
    input  logic       busy_in_n,
    input  logic       rdya,
    input  logic       rdyd,
    output bus_state_e state,
    output logic       in_seq,
    output logic       req_ready,
    output logic       accept,
    output logic       finish
);
    bus_state_e nxt;

    assign req_ready = (state == S_IDLE) || (state == S_HOLD);
    assign accept    = req_valid && req_ready;
    assign finish    = (state == S_DEND) && rdyd;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (accept) nxt = S_ARB;
            S_ARB:   if (!gnt_n && lock_in_n && busy_in_n) nxt = S_ADR;
            S_ADR:   nxt = S_AWAIT;
            S_AWAIT: if (rdya) nxt = S_DAT;
            S_DAT:   nxt = S_DEND;
            S_DEND:  if (rdyd) nxt = cur_lock ? S_HOLD : S_IDLE;
            S_HOLD:  if (accept) nxt = S_ADR;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            in_seq <= 1'b0;
        end else begin
            state <= nxt;
            if (finish) in_seq <= cur_lock;
        end
    end

    assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADR && $past(state) == S_ARB) |->
            ($past(!gnt_n) && $past(lock_in_n) && $past(busy_in_n)));

    assert_addr_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AWAIT && !rdya) |=> (state == S_AWAIT));

    assert_data_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEND && !rdyd) |=> (state == S_DEND));

    assert_no_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADR) |-> !req_ready);
endmodule

// File: rtl/mbus_xact.sv
module mbus_xact
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  xact_t            req,
    input  logic             finish,
    input  logic [BUS_W-1:0] ib_in,
    output xact_t            cur,
    output logic [BUS_W-1:0] rd_data,
    output logic             done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            if (accept) cur <= req;
            done <= finish;
            if (finish && !cur.write) rd_data <= ib_in;
        end
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bus_state_e       state,
    input  xact_t            cur,
    input  logic             in_seq,
    input  logic             gnt_n,
    output logic             bus_req_n,
    output logic             ctl_oe,
    output logic             ib_oe,
    output logic [BUS_W-1:0] ib_out,
    output logic             strba,
    output logic             strbd_n,
    output logic             busy_out_n,
    output logic             lock_out_n,
    output logic             rd_wr,
    output logic             mem_io,
    output logic             dat_ins
);
    logic addr_ph, data_ph, active, owning;

    always_comb begin
        addr_ph    = (state == S_ADR) || (state == S_AWAIT);
        data_ph    = (state == S_DAT) || (state == S_DEND);
        active     = addr_ph || data_ph;
        owning     = active || (state == S_HOLD);
        bus_req_n  = (state != S_ARB);
        ctl_oe     = owning && !gnt_n;
        ib_oe      = ctl_oe && (addr_ph || (data_ph && cur.write));
        ib_out     = data_ph ? cur.wdata : cur.addr;
        strba      = (state == S_ADR);
        strbd_n    = !data_ph;
        busy_out_n = !active;
        lock_out_n = ((state == S_HOLD) || (active && (cur.lock || in_seq)))
                     ? 1'b0 : busy_out_n;
        rd_wr      = !cur.write;
        mem_io     = cur.mem;
        dat_ins    = cur.dat;
    end

    assert_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> !ib_oe);

    assert_astrobe_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strba |=> !strba);

    assert_busy_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_out_n |-> !lock_out_n);
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic             req_data,
    input  logic             req_lock,
    output logic [BUS_W-1:0] rd_data,
    output logic             done,
    output logic             bus_req_n,
    input  logic             bus_gnt_n,
    input  logic             busy_in_n,
    input  logic             lock_in_n,
    output logic             busy_out_n,
    output logic             lock_out_n,
    input  logic             rdya,
    input  logic             rdyd,
    input  logic [BUS_W-1:0] ib_in,
    output logic [BUS_W-1:0] ib_out,
    output logic             ib_oe,
    output logic             ctl_oe,
    output logic             strba,
    output logic             strbd_n,
    output logic             rd_wr,
    output logic             mem_io,
    output logic             dat_ins
);
    bus_state_e state;
    xact_t      req, cur;
    logic       in_seq, accept, finish;

    assign req = '{addr: req_addr, wdata: req_wdata, write: req_write,
                   mem: req_mem, dat: req_data, lock: req_lock};

    mbus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lock(cur.lock),
        .gnt_n(bus_gnt_n), .lock_in_n(lock_in_n), .busy_in_n(busy_in_n),
        .rdya(rdya), .rdyd(rdyd), .state(state), .in_seq(in_seq),
        .req_ready(req_ready), .accept(accept), .finish(finish)
    );

    mbus_xact u_xact (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req(req), .finish(finish),
        .ib_in(ib_in), .cur(cur), .rd_data(rd_data), .done(done)
    );

    mbus_drive u_drive (
        .clk(clk), .rst_n(rst_n), .state(state), .cur(cur), .in_seq(in_seq),
        .gnt_n(bus_gnt_n), .bus_req_n(bus_req_n), .ctl_oe(ctl_oe),
        .ib_oe(ib_oe), .ib_out(ib_out), .strba(strba), .strbd_n(strbd_n),
        .busy_out_n(busy_out_n), .lock_out_n(lock_out_n), .rd_wr(rd_wr),
        .mem_io(mem_io), .dat_ins(dat_ins)
    );
endmodule

// File: tb/test_mbus_ctrl.sv
module test_mbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic        req_data = 1'b0, req_lock = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, ib_in = '0;
    logic        bus_gnt_n = 1'b0, busy_in_n = 1'b1, lock_in_n = 1'b1;
    logic        rdya = 1'b1, rdyd = 1'b1;
    logic        req_ready, done, bus_req_n, busy_out_n, lock_out_n;
    logic        ib_oe, ctl_oe, strba, strbd_n, rd_wr, mem_io, dat_ins;
    logic [15:0] rd_data, ib_out;
    int          checks = 0, errors = 0;
    bit          holding = 1'b0, finished = 1'b0;

    always #5 clk = ~clk;

    mbus_ctrl i_mbus_ctrl (.*);

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int aw, input int dw);
        return 4 + aw + dw;
    endfunction

    task automatic xfer(input logic [15:0] a, input logic [15:0] wd, input logic wr,
                        input logic mm, input logic dt, input logic lk,
                        input int aw, input int dw, input int arbw, input int mode,
                        input logic [15:0] rdv);
        int n;
        bit from_hold;
        from_hold = holding;
        while (!req_ready) @(negedge clk);
        chk("R12 ready before", req_ready, 1);
        req_valid = 1; req_addr = a; req_wdata = wd; req_write = wr;
        req_mem = mm; req_data = dt; req_lock = lk;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk("R11 done one clock", done, 0);
        if (!from_hold) begin
            chk("R2 request low", bus_req_n, 0);
            chk("R4 float unowned", ctl_oe, 0);
            if (arbw > 0) begin
                if (mode == 0) bus_gnt_n = 1;
                else if (mode == 1) lock_in_n = 0;
                else busy_in_n = 0;
            end
            for (int i = 0; i < arbw; i++) begin
                @(posedge clk); @(negedge clk);
                chk("R3 still waiting", bus_req_n, 0);
                chk("R3 no strobe", strba, 0);
                chk("R4 float waiting", {ctl_oe, ib_oe}, 0);
                if (i == arbw - 1) begin
                    bus_gnt_n = 0; lock_in_n = 1; busy_in_n = 1;
                end
            end
            @(posedge clk); @(negedge clk);
        end
        n = 0;
        chk("R2 request released", bus_req_n, 1);
        chk("R5 strobe first clock", strba, 1);
        chk("R5 address driven", {ib_oe, ib_out}, {1'b1, a});
        chk("R8 status", {rd_wr, mem_io, dat_ins}, {~wr, mm, dt});
        chk("R9 busy and lock", {ctl_oe, busy_out_n, lock_out_n}, 3'b100);
        chk("R12 busy no ready", req_ready, 0);
        rdyd = 0;
        for (int i = 0; i <= aw; i++) begin
            @(posedge clk); @(negedge clk); n++;
            chk("R5 address phase", {strba, strbd_n, ib_oe, ib_out}, {3'b011, a});
            chk("R6 rdyd ignored", busy_out_n, 0);
            rdya = (i == aw);
        end
        @(posedge clk); @(negedge clk); n++;
        rdya = 0;
        ib_in = rdv;
        chk("R6 data strobe", {strba, strbd_n}, 2'b00);
        if (wr) chk("R6 write data", {ib_oe, ib_out}, {1'b1, wd});
        else    chk("R6 read release", ib_oe, 0);
        for (int j = 0; j <= dw; j++) begin
            @(posedge clk); @(negedge clk); n++;
            chk("R6 data phase", {strbd_n, lock_out_n, busy_out_n}, 3'b000);
            if (wr) chk("R6 write held", ib_out, wd);
            else    chk("R6 read held", ib_oe, 0);
            rdyd = (j == dw);
        end
        @(posedge clk); @(negedge clk); n++;
        rdya = 1; rdyd = 1;
        chk("R7 cycle length", n, exp_cycles(aw, dw));
        chk("R11 done", done, 1);
        if (!wr) chk("R11 read data", rd_data, rdv);
        chk("R12 ready after", req_ready, 1);
        if (lk) begin
            chk("R10 hold locked", {ctl_oe, busy_out_n, lock_out_n, bus_req_n}, 4'b1101);
            holding = 1;
        end else begin
            chk("R4 released", {ctl_oe, ib_oe}, 0);
            holding = 0;
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 reset", {req_ready, bus_req_n, ctl_oe, ib_oe, done}, 5'b11000);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", {req_ready, bus_req_n, ctl_oe, done}, 4'b1100);

        xfer(16'h1234, 16'hbeef, 1, 1, 1, 0, 0, 0, 0, 0, 16'h0);
        xfer(16'h8001, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0, 16'ha5c3);
        xfer(16'h00ff, 16'h0, 0, 1, 0, 0, 3, 2, 2, 1, 16'h5a5a);
        xfer(16'hf00f, 16'h7777, 1, 0, 1, 0, 1, 4, 3, 2, 16'h0);

        xfer(16'h0100, 16'h0, 0, 1, 1, 1, 0, 1, 1, 0, 16'h1111);
        @(negedge clk);
        bus_gnt_n = 1;
        #1 chk("R4 float in hold", {ctl_oe, ib_oe}, 0);
        bus_gnt_n = 0;
        #1 chk("R10 lock kept", {ctl_oe, lock_out_n, busy_out_n}, 3'b101);
        xfer(16'h0100, 16'h2222, 1, 1, 1, 1, 1, 0, 0, 0, 16'h0);
        xfer(16'h0102, 16'h3333, 1, 1, 1, 0, 0, 0, 0, 0, 16'h0);
        @(negedge clk);
        chk("R10 lock released", {ctl_oe, bus_req_n}, 2'b01);

        for (int k = 0; k < 30; k++) begin
            xfer(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'b0, int'($urandom % 4), int'($urandom % 4),
                 int'($urandom % 4), int'($urandom % 3), 16'($urandom));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule